// File: doc/BRIEF.md
# Register Rename Map with Free-Location Pool

This block sits in the front end of an out-of-order core. It renames one instruction per cycle. Each instruction has two source operands and an optional destination. A source operand is either an architectural register name or an immediate constant. The block looks each register source up in a map table, which holds the physical location most recently assigned to that name. An immediate passes through unchanged and is marked as a constant.

When the instruction writes a destination, the block takes a fresh physical location from a pool of unallocated locations and points the destination name at it. Sources are resolved against the map as it stood before this instruction's own destination update. This removes false write-after-read and write-after-write dependences while true read-after-write dependences are kept.

The pool is a circular queue of location indices. Allocation takes from its head and a release port returns locations to its tail. When the pool is empty, the block drops `rename_ready` and accepts nothing. All results are registered, so they appear on the cycle after the instruction is accepted.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural name k maps to physical location k, `rename_ready` is 1 and `out_valid` is 0.
- R2: After reset the pool holds locations NUM_ARCH to NUM_PHYS-1, and they are handed out in ascending order (with 4 names and 8 locations: 4, 5, 6, 7).
- R3: A register source reads the mapping in force before the same instruction's destination update. The next accepted instruction sees the new mapping (r3=r3*r3 reads r3 as p5 and then remaps r3 to p6).
- R4: A source whose immediate flag is 1 comes out unchanged on its output field with its constant flag at 1. A register source comes out as the zero-extended physical location with its constant flag at 0.
- R5: While the pool is empty, `rename_ready` is 0. An instruction presented then is not accepted: `out_valid` stays 0 on the next cycle and no mapping changes.
- R6: Released locations are handed out in the order they were released, after those already in the pool. A release and an allocation in the same cycle both take effect.
- R7: Location 0 is never handed out. A release of location 0 is dropped.
- R8: An instruction is accepted when `in_valid` and `rename_ready` are both 1. It appears with `out_valid`=1 on the next cycle, and `out_dst_valid` equals its `dst_en`. Without `dst_en` no location is consumed and `out_dst` is 0.
- R9: A release of a nonzero location into an empty pool raises `rename_ready` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| src1_opnd | input | OPND_W | First source: register name in the low bits, or an immediate |
| src1_imm | input | 1 | First source is an immediate |
| src2_opnd | input | OPND_W | Second source: register name in the low bits, or an immediate |
| src2_imm | input | 1 | Second source is an immediate |
| dst_en | input | 1 | Instruction writes a destination |
| dst_name | input | ARCH_W | Destination architectural name |
| rel_valid | input | 1 | Return a location to the pool |
| rel_phys | input | PHYS_W | Location being returned |
| rename_ready | output | 1 | Pool not empty; an instruction can be accepted |
| out_valid | output | 1 | Renamed instruction valid |
| out_src1 | output | OPND_W | First source: physical location or immediate |
| out_src1_const | output | 1 | First source is a constant |
| out_src2 | output | OPND_W | Second source: physical location or immediate |
| out_src2_const | output | 1 | Second source is a constant |
| out_dst_valid | output | 1 | Destination location allocated |
| out_dst | output | PHYS_W | Allocated destination location |

## Verification
The hardest state to reach from the ports is an empty pool that receives a release in the same cycle as an instruction is presented, combined with a release of location 0. The stimulus first drains the pool with the four-instruction example sequence. It then offers an instruction while the pool is empty and returns superseded locations one at a time. Next it overlaps a release with an allocation, so the queue order after wrap-around is visible in the allocated destinations. A long random phase follows. In it, the bench releases only locations that a later rename has superseded, and it mixes in releases of location 0. A queue-based model predicts every output on every cycle.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Default sizing shared by the block and its bench
  localparam int DEF_NUM_ARCH = 4;
  localparam int DEF_NUM_PHYS = 8;
  localparam int DEF_OPND_W   = 8;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 4,
  parameter int NUM_PHYS = 8,
  parameter int N_RD     = 2,
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_RD-1:0][ARCH_W-1:0]  rd_name,
  output logic [N_RD-1:0][PHYS_W-1:0]  rd_phys,
  input  logic                         wr_en,
  input  logic [ARCH_W-1:0]            wr_name,
  input  logic [PHYS_W-1:0]            wr_phys
);
  logic [PHYS_W-1:0] map_q [NUM_ARCH];

  // Write port: identity mapping on reset, remap on allocation
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_ARCH; k++) map_q[k] <= PHYS_W'(k);
    end else if (wr_en) begin
      map_q[wr_name] <= wr_phys;
    end
  end

  // Asynchronous read ports (distributed memory style)
  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_phys[r] = map_q[rd_name[r]];
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = 4,
  parameter int NUM_PHYS = 8,
  localparam int PHYS_W  = $clog2(NUM_PHYS),
  localparam int CNT_W   = PHYS_W + 1,
  localparam int INIT_FREE = NUM_PHYS - NUM_ARCH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop,
  output logic [PHYS_W-1:0] pop_data,
  output logic              has_free,
  input  logic              push,
  input  logic [PHYS_W-1:0] push_data
);
  localparam logic [PHYS_W-1:0] LAST_IDX = PHYS_W'(NUM_PHYS - 1);

  logic [PHYS_W-1:0] slot_q [NUM_PHYS];
  logic [PHYS_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  // Location 0 never enters the pool
  assign push_ok  = push && (push_data != '0);
  assign pop_ok   = pop && (cnt_q != '0);
  assign has_free = (cnt_q != '0);
  assign pop_data = slot_q[head_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++)
        slot_q[i] <= (i < INIT_FREE) ? PHYS_W'(NUM_ARCH + i) : '0;
    end else if (push_ok) begin
      slot_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= PHYS_W'(INIT_FREE % NUM_PHYS);
      cnt_q  <= CNT_W'(INIT_FREE);
    end else begin
      if (pop_ok)  head_q <= (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
      if (push_ok) tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/rn_src_sel.sv
module rn_src_sel #(
  parameter int OPND_W = 8,
  parameter int PHYS_W = 3
) (
  input  logic [OPND_W-1:0] opnd,
  input  logic              is_imm,
  input  logic [PHYS_W-1:0] mapped,
  output logic [OPND_W-1:0] value,
  output logic              is_const
);
  always_comb begin
    value    = is_imm ? opnd : OPND_W'(mapped);
    is_const = is_imm;
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit import rename_pkg::*; #(
  parameter int NUM_ARCH = DEF_NUM_ARCH,
  parameter int NUM_PHYS = DEF_NUM_PHYS,
  parameter int OPND_W   = DEF_OPND_W,
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPND_W-1:0] src1_opnd,
  input  logic              src1_imm,
  input  logic [OPND_W-1:0] src2_opnd,
  input  logic              src2_imm,
  input  logic              dst_en,
  input  logic [ARCH_W-1:0] dst_name,
  input  logic              rel_valid,
  input  logic [PHYS_W-1:0] rel_phys,
  output logic              rename_ready,
  output logic              out_valid,
  output logic [OPND_W-1:0] out_src1,
  output logic              out_src1_const,
  output logic [OPND_W-1:0] out_src2,
  output logic              out_src2_const,
  output logic              out_dst_valid,
  output logic [PHYS_W-1:0] out_dst
);
  localparam int N_SRC = 2;

  logic                         accept, alloc;
  logic [PHYS_W-1:0]            fresh_phys;
  logic [N_SRC-1:0][ARCH_W-1:0] rd_name;
  logic [N_SRC-1:0][PHYS_W-1:0] rd_phys;
  logic [OPND_W-1:0]            opnd_in  [N_SRC];
  logic                         imm_in   [N_SRC];
  logic [OPND_W-1:0]            sel_val  [N_SRC];
  logic                         sel_cnst [N_SRC];

  assign accept = in_valid && rename_ready;
  assign alloc  = accept && dst_en;

  assign opnd_in[0] = src1_opnd;
  assign opnd_in[1] = src2_opnd;
  assign imm_in[0]  = src1_imm;
  assign imm_in[1]  = src2_imm;

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk      (clk),
    .rst      (rst),
    .pop      (alloc),
    .pop_data (fresh_phys),
    .has_free (rename_ready),
    .push     (rel_valid),
    .push_data(rel_phys)
  );

  // Reads see the table before this cycle's write lands
  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .N_RD(N_SRC)) u_map (
    .clk    (clk),
    .rst    (rst),
    .rd_name(rd_name),
    .rd_phys(rd_phys),
    .wr_en  (alloc),
    .wr_name(dst_name),
    .wr_phys(fresh_phys)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign rd_name[s] = opnd_in[s][ARCH_W-1:0];
    rn_src_sel #(.OPND_W(OPND_W), .PHYS_W(PHYS_W)) u_sel (
      .opnd    (opnd_in[s]),
      .is_imm  (imm_in[s]),
      .mapped  (rd_phys[s]),
      .value   (sel_val[s]),
      .is_const(sel_cnst[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_src1       <= '0;
      out_src1_const <= 1'b0;
      out_src2       <= '0;
      out_src2_const <= 1'b0;
      out_dst_valid  <= 1'b0;
      out_dst        <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src1       <= sel_val[0];
        out_src1_const <= sel_cnst[0];
        out_src2       <= sel_val[1];
        out_src2_const <= sel_cnst[1];
        out_dst_valid  <= dst_en;
        out_dst        <= dst_en ? fresh_phys : '0;
      end
    end
  end
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int OPND_W = 8,
  parameter int PHYS_W = 3,
  parameter int ARCH_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OPND_W-1:0] src1_opnd,
  input logic              src1_imm,
  input logic [OPND_W-1:0] src2_opnd,
  input logic              src2_imm,
  input logic              dst_en,
  input logic              rel_valid,
  input logic [PHYS_W-1:0] rel_phys,
  input logic              rename_ready,
  input logic              out_valid,
  input logic [OPND_W-1:0] out_src1,
  input logic              out_src1_const,
  input logic [OPND_W-1:0] out_src2,
  input logic              out_src2_const,
  input logic              out_dst_valid,
  input logic [PHYS_W-1:0] out_dst
);
  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    in_valid && !rename_ready |=> !out_valid); // R5

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (rst)
    in_valid && rename_ready |=> out_valid); // R8

  AST_DST_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && rename_ready |=> out_dst_valid == $past(dst_en)); // R8

  AST_IMM_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid && rename_ready && src1_imm |=> out_src1_const && out_src1 == $past(src1_opnd)); // R4

  AST_REG_NOT_CONST: assert property (@(posedge clk) disable iff (rst)
    in_valid && rename_ready && !src2_imm |=> !out_src2_const); // R4

  AST_NO_ZERO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_dst_valid |-> out_dst != '0); // R7

  AST_RELEASE_READY: assert property (@(posedge clk) disable iff (rst)
    rel_valid && rel_phys != '0 |=> rename_ready); // R9

  AST_SAME_NAME: assert property (@(posedge clk) disable iff (rst)
    in_valid && rename_ready && !src1_imm && !src2_imm &&
    src1_opnd[ARCH_W-1:0] == src2_opnd[ARCH_W-1:0] |=> out_src1 == out_src2); // R3
endmodule

bind rename_unit rename_unit_chk #(.OPND_W(OPND_W), .PHYS_W(PHYS_W), .ARCH_W(ARCH_W)) u_chk (.*);

// File: tb/tb_rename_unit.sv
module tb_rename_unit;
  import rename_pkg::*;
  localparam int NA = DEF_NUM_ARCH;
  localparam int NP = DEF_NUM_PHYS;
  localparam int OW = DEF_OPND_W;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, src1_imm, src2_imm, dst_en, rel_valid;
  logic [OW-1:0] src1_opnd, src2_opnd;
  logic [AW-1:0] dst_name;
  logic [PW-1:0] rel_phys;
  logic rename_ready, out_valid, out_src1_const, out_src2_const, out_dst_valid;
  logic [OW-1:0] out_src1, out_src2;
  logic [PW-1:0] out_dst;

  rename_unit dut (.*);

  int checks = 0, errors = 0;
  int mdl_map [NA];
  int mdl_free [$];
  int pend [$];
  bit e_valid, e_c1, e_c2, e_dv;
  int e_s1, e_s2, e_dst;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NA; k++) mdl_map[k] = k;
    mdl_free.delete();
    pend.delete();
    for (int p = NA; p < NP; p++) mdl_free.push_back(p);
  endtask

  // One cycle: drive after a falling edge, update model at the rising edge,
  // compare registered outputs at the next falling edge.
  task automatic cyc(bit v, int s1, bit i1, int s2, bit i2, bit de, int dn, bit rv, int rp);
    bit rdy;
    in_valid = v; src1_opnd = OW'(s1); src1_imm = i1; src2_opnd = OW'(s2); src2_imm = i2;
    dst_en = de; dst_name = AW'(dn); rel_valid = rv; rel_phys = PW'(rp);
    #1;
    rdy = (mdl_free.size() > 0);
    check(rename_ready == rdy, "R5/R9 rename_ready", rename_ready, rdy);
    @(posedge clk);
    e_valid = v && rdy;
    if (e_valid) begin
      e_s1 = i1 ? s1 : mdl_map[s1 % NA];
      e_s2 = i2 ? s2 : mdl_map[s2 % NA];
      e_c1 = i1; e_c2 = i2; e_dv = de; e_dst = 0;
      if (de) begin
        e_dst = mdl_free.pop_front();
        pend.push_back(mdl_map[dn]);
        mdl_map[dn] = e_dst;
      end
    end
    if (rv && rp != 0) mdl_free.push_back(rp);
    @(negedge clk);
    check(out_valid == e_valid, "R8 out_valid", out_valid, e_valid);
    if (e_valid) begin
      check(int'(out_src1) == e_s1, "R3 out_src1", out_src1, e_s1);
      check(int'(out_src2) == e_s2, "R3 out_src2", out_src2, e_s2);
      check(out_src1_const == e_c1, "R4 out_src1_const", out_src1_const, e_c1);
      check(out_src2_const == e_c2, "R4 out_src2_const", out_src2_const, e_c2);
      check(out_dst_valid == e_dv, "R8 out_dst_valid", out_dst_valid, e_dv);
      check(int'(out_dst) == e_dst, "R2 out_dst", out_dst, e_dst);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog expired actual 0 expected 1");
    summary();
  end

  initial begin
    int rp;
    rst = 1'b1; in_valid = 0; src1_opnd = 0; src1_imm = 0; src2_opnd = 0; src2_imm = 0;
    dst_en = 0; dst_name = 0; rel_valid = 0; rel_phys = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(rename_ready == 1'b1, "R1 ready after reset", rename_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    @(negedge clk);

    // R1: identity mapping
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 0);
    check(out_src1 == 0 && out_src2 == 1, "R1 identity 0/1", out_src2, 1);
    cyc(1, 2, 0, 3, 0, 0, 0, 0, 0);
    check(out_src1 == 2 && out_src2 == 3, "R1 identity 2/3", out_src1, 2);
    check(out_dst_valid == 0 && out_dst == 0, "R8 no dst no alloc", out_dst, 0);

    // R2/R3/R4: worked sequence
    cyc(1, 2, 0, 3, 0, 1, 1, 0, 0);
    check(out_dst == 4, "R2 first alloc", out_dst, 4);
    cyc(1, 2, 0, 1, 0, 1, 3, 0, 0);
    check(out_src2 == 4 && out_dst == 5, "R3 reads new r1 / R2 alloc 5", out_dst, 5);
    cyc(1, 3, 0, 3, 0, 1, 3, 0, 0);
    check(out_src1 == 5 && out_src2 == 5, "R3 pre-update source", out_src1, 5);
    check(out_dst == 6, "R2 alloc 6", out_dst, 6);
    cyc(1, 1, 0, 4, 1, 1, 1, 0, 0);
    check(out_src1 == 4 && out_dst == 7, "R2 alloc 7", out_dst, 7);
    check(out_src2 == 4 && out_src2_const == 1, "R4 immediate passthrough", out_src2, 4);

    // R5: empty pool stalls
    #1;
    check(rename_ready == 0, "R5 empty pool not ready", rename_ready, 0);
    cyc(1, 2, 0, 2, 0, 1, 2, 0, 0);
    check(out_valid == 0, "R5 stalled instruction dropped", out_valid, 0);

    // R9: release into empty pool
    rp = pend.pop_front();
    cyc(0, 0, 0, 0, 0, 0, 0, 1, rp);
    #1;
    check(rename_ready == 1, "R9 ready after release", rename_ready, 1);
    cyc(1, 2, 0, 0, 0, 0, 0, 1, 0);
    check(out_src1 == 2, "R5 map unchanged by stall", out_src1, 2);
    cyc(1, 1, 0, 1, 0, 1, 2, 0, 0);
    check(out_src1 == 7 && out_dst == 1, "R6 released location reused", out_dst, 1);
    #1;
    check(rename_ready == 0, "R7 location 0 not in pool", rename_ready, 0);

    // R6: release and allocation in the same cycle
    rp = pend.pop_front();
    cyc(0, 0, 0, 0, 0, 0, 0, 1, rp);
    rp = pend.pop_front();
    cyc(1, 2, 0, 2, 0, 1, 3, 1, rp);
    check(out_src1 == 1 && out_dst == 3, "R6 alloc during release", out_dst, 3);
    cyc(1, 3, 0, 9, 1, 1, 0, 0, 0);
    check(out_src1 == 3 && out_dst == 5, "R6 FIFO order after overlap", out_dst, 5);

    // Random phase against the model
    for (int n = 0; n < 600; n++) begin
      bit rv;
      int rpv;
      rv = 0; rpv = 0;
      if (($urandom % 3) == 0 && pend.size() > 0) begin
        rv = 1; rpv = pend.pop_front();
      end else if (($urandom % 10) == 0) begin
        rv = 1; rpv = 0;
      end
      cyc(($urandom % 4) != 0, $urandom % 256, ($urandom % 4) == 0,
          $urandom % 256, ($urandom % 4) == 0, ($urandom % 4) != 0,
          $urandom % NA, rv, rpv);
    end
    summary();
  end
endmodule